// File: doc/BRIEF.md
# DMA Control Register with Shared Terminal-Count Pin

This block holds the 8-bit control word of a four-channel DMA controller: a priority-mode bit, an enable for the terminal-count pin function and one pending-request flag per channel. Software reads the whole word back at any time. It writes the word in one access. A request flag only changes when software writes a 0 to it, so a write can update the mode bits and leave pending requests alone. Hardware request strobes set the flags.

While the pin function is off, the shared pin is an ordinary push-pull general-purpose output that follows the port logic. While the pin function is on, the pin becomes open-drain and serves two purposes. A normal batch completion pulls it low for one clock. An external high-to-low transition on it, seen while a transfer is running, raises a one-cycle force-terminate strobe. The block ignores the low level it drives itself, so its own completion pulse is never taken as an abort.

Top module: `dmac_ctrl_tc`

## Requirements
- R1: After reset, rd_data is 0x00, force_terminate is 0, and the pin follows gpio_oe/gpio_out.
- R2: Bit 0 of the word selects priority mode (0 fixed, 1 rotating). It is written from wr_data[0], read back on rd_data[0] and shown on prio_rotate.
- R3: Bit 1 of the word enables the terminal-count pin function. It is written from wr_data[1], read back on rd_data[1] and shown on tc_enable.
- R4: Bits 2 and 3 always read as 0, and writing them has no effect.
- R5: A write with wr_data[4+i]=1 leaves request flag i (rd_data[4+i], channel i) unchanged.
- R6: A write with wr_data[4+i]=0 clears request flag i, unless a hardware request sets it in the same cycle.
- R7: hw_req[i] high at a clock edge sets flag i on that edge, and the set overrides a clear written in the same cycle.
- R8: With the pin function on, a batch_done strobe makes pin_oe=1 with pin_out=0 for exactly the next cycle, after which the pin is released.
- R9: With the pin function off, pin_out and pin_oe follow gpio_out and gpio_oe, and batch_done has no effect on the pin.
- R10: With the pin function on, pin_out is always 0, and pin_oe ignores gpio_oe.
- R11: With the pin function on and transfer_active high, a falling edge on pin_in raises force_terminate for one cycle. The strobe appears in the second cycle after the cycle in which the low level is first sampled.
- R12: force_terminate stays 0 when transfer_active is low or the pin function is off.
- R13: The low level the block drives itself never raises force_terminate. Edge detection is masked while the block drives the pin and for SYNC_STAGES+1 cycles after it releases the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Register read value |
| hw_req | input | NUM_CH | Per-channel hardware request set strobes |
| batch_done | input | 1 | Normal end-of-batch strobe |
| transfer_active | input | 1 | A DMA transfer is in progress |
| force_terminate | output | 1 | One-cycle forced-termination strobe |
| prio_rotate | output | 1 | Priority mode: 1 rotating, 0 fixed |
| tc_enable | output | 1 | Terminal-count pin function enabled |
| req_flags | output | NUM_CH | Pending request flags |
| gpio_out | input | 1 | Port data when the pin is general-purpose |
| gpio_oe | input | 1 | Port output enable when the pin is general-purpose |
| pin_in | input | 1 | Level seen on the pin |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench builds the block with its default parameters: four channels, an 8-bit word and a two-stage synchronizer. With four channels, flag patterns can mix kept, cleared and hardware-set flags in a single write. With two synchronizer stages, the masking window after the block's own pulse is three cycles. The bench loops pin_out back onto pin_in whenever pin_oe is high. The self-generated low pulse therefore travels through the same synchronizer as an external abort, and the bench can tell the two cases apart on force_terminate.

// File: rtl/dmac_ctrl_pkg.sv
package dmac_ctrl_pkg;
  // Field positions inside the control word (read back by software)
  localparam int PRIO_BIT = 0;
  localparam int TCEN_BIT = 1;
  localparam int REQ_LSB  = 4;
endpackage

// File: rtl/dmac_ctrl_reg.sv
module dmac_ctrl_reg
  import dmac_ctrl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_CH-1:0] hw_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              prio_rotate,
  output logic              tc_enable,
  output logic [NUM_CH-1:0] req_flags
);
  localparam int REQ_MSB = REQ_LSB + NUM_CH - 1;

  logic              prio_q, prio_d;
  logic              tcen_q, tcen_d;
  logic [NUM_CH-1:0] req_q,  req_d;

  // Mode bits: plain load on write
  always_comb begin
    prio_d = prio_q;
    tcen_d = tcen_q;
    if (wr_en) begin
      prio_d = wr_data[PRIO_BIT];
      tcen_d = wr_data[TCEN_BIT];
    end
  end

  // Request flags: written 0 clears, written 1 keeps, hardware set wins
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_req
    always_comb begin
      req_d[ch] = req_q[ch];
      if (wr_en && !wr_data[REQ_LSB+ch]) req_d[ch] = 1'b0;
      if (hw_req[ch])                    req_d[ch] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= 1'b0;
      tcen_q <= 1'b0;
      req_q  <= '0;
    end else begin
      prio_q <= prio_d;
      tcen_q <= tcen_d;
      req_q  <= req_d;
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[PRIO_BIT]        = prio_q;
    rd_data[TCEN_BIT]        = tcen_q;
    rd_data[REQ_MSB:REQ_LSB] = req_q;
  end

  assign prio_rotate = prio_q;
  assign tc_enable   = tcen_q;
  assign req_flags   = req_q;
endmodule

// File: rtl/dmac_tc_driver.sv
module dmac_tc_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic tc_enable,
  input  logic batch_done,
  input  logic gpio_out,
  input  logic gpio_oe,
  output logic tc_drive,
  output logic pin_out,
  output logic pin_oe
);
  logic drive_q, drive_d;

  always_comb begin
    drive_d = tc_enable & batch_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= drive_d;
  end

  // Open-drain in terminal-count mode: only ever drive low
  always_comb begin
    if (tc_enable) begin
      pin_out = 1'b0;
      pin_oe  = drive_q;
    end else begin
      pin_out = gpio_out;
      pin_oe  = gpio_oe;
    end
  end

  assign tc_drive = drive_q;
endmodule

// File: rtl/dmac_abort_detect.sv
module dmac_abort_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic tc_enable,
  input  logic transfer_active,
  input  logic tc_drive,
  output logic force_terminate
);
  localparam int MASK_LEN = SYNC_STAGES + 1;
  localparam int CNT_W    = $clog2(MASK_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic [CNT_W-1:0]       mask_q, mask_d;
  logic                   sync_lvl;
  logic                   fall_seen;
  logic                   masked;

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_in};
    prev_d = sync_lvl;
  end

  // Mask window follows own drive through the synchronizer
  always_comb begin
    mask_d = mask_q;
    if (tc_drive)           mask_d = CNT_W'(MASK_LEN);
    else if (mask_q != '0)  mask_d = mask_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      mask_q <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      mask_q <= mask_d;
    end
  end

  assign fall_seen       = prev_q & ~sync_lvl;
  assign masked          = tc_drive | (mask_q != '0);
  assign force_terminate = fall_seen & ~masked & tc_enable & transfer_active;
endmodule

// File: rtl/dmac_ctrl_tc.sv
module dmac_ctrl_tc #(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic              batch_done,
  input  logic              transfer_active,
  output logic              force_terminate,
  output logic              prio_rotate,
  output logic              tc_enable,
  output logic [NUM_CH-1:0] req_flags,
  input  logic              gpio_out,
  input  logic              gpio_oe,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe
);
  logic tc_drive;

  dmac_ctrl_reg #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) reg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_req(hw_req), .rd_data(rd_data), .prio_rotate(prio_rotate),
    .tc_enable(tc_enable), .req_flags(req_flags)
  );

  dmac_tc_driver drv_i (
    .clk(clk), .rst_n(rst_n), .tc_enable(tc_enable),
    .batch_done(batch_done), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .tc_drive(tc_drive), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  dmac_abort_detect #(.SYNC_STAGES(SYNC_STAGES)) det_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tc_enable(tc_enable),
    .transfer_active(transfer_active), .tc_drive(tc_drive),
    .force_terminate(force_terminate)
  );
endmodule

// File: rtl/dmac_ctrl_tc_chk.sv
module dmac_ctrl_tc_chk #(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_CH-1:0] hw_req,
  input logic              batch_done,
  input logic              transfer_active,
  input logic              force_terminate,
  input logic              tc_enable,
  input logic              pin_out,
  input logic              pin_oe
);
  localparam int WIN   = SYNC_STAGES + 1;
  localparam int WIN_W = $clog2(WIN + 1);

  logic [WIN_W-1:0] win_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     win_q <= '0;
    else if (tc_enable && pin_oe)   win_q <= WIN_W'(WIN);
    else if (win_q != '0)           win_q <= win_q - 1'b1;
  end

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3:2] == 2'b00);

  assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_enable && batch_done) |=> (pin_oe && !pin_out));

  assert_pulse_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_enable && !batch_done) |=> (!pin_oe || !tc_enable));

  assert_never_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tc_enable |-> !pin_out);

  assert_force_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    force_terminate |=> !force_terminate);

  assert_force_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    force_terminate |-> (transfer_active && tc_enable));

  assert_self_mask_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_q != '0) || (tc_enable && pin_oe)) |-> !force_terminate);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_req_chk
    assert_hw_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hw_req[ch] |=> rd_data[4+ch]);
    assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[4+ch] && rd_data[4+ch]) |=> rd_data[4+ch]);
  end
endmodule

bind dmac_ctrl_tc dmac_ctrl_tc_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .hw_req(hw_req), .batch_done(batch_done),
  .transfer_active(transfer_active), .force_terminate(force_terminate),
  .tc_enable(tc_enable), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/dmac_ctrl_tc_tb_top.sv
module dmac_ctrl_tc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] hw_req = '0;
  logic       batch_done = 1'b0;
  logic       transfer_active = 1'b0;
  logic       force_terminate, prio_rotate, tc_enable;
  logic [3:0] req_flags;
  logic       gpio_out = 1'b0, gpio_oe = 1'b0;
  logic       ext_lvl = 1'b1;
  logic       pin_in, pin_out, pin_oe;

  // Pull-up with loopback of the driven level
  assign pin_in = pin_oe ? pin_out : ext_lvl;

  always #10 clk = ~clk;  // 50 MHz

  dmac_ctrl_tc dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .hw_req(hw_req), .batch_done(batch_done),
    .transfer_active(transfer_active), .force_terminate(force_terminate),
    .prio_rotate(prio_rotate), .tc_enable(tc_enable), .req_flags(req_flags),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Scoreboard queue: observed = {force, pin_oe, pin_out, rd_data}
  int          q_cyc[$];
  logic [10:0] q_val[$];
  logic [10:0] q_msk[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int d, string tag, logic [10:0] val, logic [10:0] msk);
    q_cyc.push_back(cyc + d);
    q_val.push_back(val);
    q_msk.push_back(msk);
    q_tag.push_back(tag);
  endtask

  localparam logic [10:0] M_ALL = 11'h7FF;
  localparam logic [10:0] M_RD  = 11'h0FF;
  localparam logic [10:0] M_F   = 11'h400;
  localparam logic [10:0] M_PIN = 11'h300;

  // Monitor: samples 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    for (int i = q_cyc.size() - 1; i >= 0; i--) begin
      if (q_cyc[i] <= cyc) begin
        logic [10:0] obs;
        obs = {force_terminate, pin_oe, pin_out, rd_data};
        checks++;
        if (q_cyc[i] < cyc || ((obs & q_msk[i]) != (q_val[i] & q_msk[i]))) begin
          failures++;
          $display("FAIL %s cyc=%0d actual=%03h expected=%03h mask=%03h",
                   q_tag[i], cyc, obs & q_msk[i], q_val[i] & q_msk[i], q_msk[i]);
        end
        q_cyc.delete(i); q_val.delete(i); q_msk.delete(i); q_tag.delete(i);
      end
    end
  end

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic reg_write(logic [7:0] d, logic [3:0] hr, logic [7:0] exp_rd, string tag);
    wr_en = 1'b1; wr_data = d; hw_req = hr;
    expect_at(1, tag, {3'b000, exp_rd}, M_RD);
    tick(1);
    wr_en = 1'b0; hw_req = '0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1: reset state
    expect_at(1, "R1", 11'h000, M_ALL);
    tick(2);

    // R9: general-purpose mode follows port, batch_done ignored
    gpio_oe = 1'b1; gpio_out = 1'b1; batch_done = 1'b1;
    expect_at(1, "R9", 11'h300, M_PIN);
    expect_at(2, "R9", 11'h300, M_PIN);
    tick(1); batch_done = 1'b0; tick(2);
    gpio_out = 1'b0;
    expect_at(1, "R9", 11'h200, M_PIN);
    tick(2);

    // R2 priority bit; R4 reserved bits ignored; R5 ones keep cleared flags at 0
    reg_write(8'h01, 4'h0, 8'h01, "R2");
    reg_write(8'hFD, 4'h0, 8'h01, "R4");
    // R7 hardware set
    hw_req = 4'b0101;
    expect_at(1, "R7", 11'h051, M_RD);
    tick(1); hw_req = '0;
    // R5 write ones keeps all flags
    reg_write(8'hF1, 4'h0, 8'h51, "R5");
    // R6 zeros clear except ch0
    reg_write(8'h11, 4'h0, 8'h11, "R6");
    // R7 set beats clear in same cycle on ch1
    reg_write(8'h01, 4'b0010, 8'h21, "R7");
    reg_write(8'h00, 4'h0, 8'h00, "R6");

    // R3 enable pin function; R10 port inputs ignored
    gpio_oe = 1'b1; gpio_out = 1'b1;
    reg_write(8'h02, 4'h0, 8'h02, "R3");
    expect_at(1, "R10", 11'h002, M_ALL);
    tick(3);

    // R8 pulse, R13 own pulse not an abort
    transfer_active = 1'b1;
    batch_done = 1'b1;
    expect_at(1, "R8", 11'h200, M_PIN | M_F);
    expect_at(2, "R8", 11'h000, M_PIN);
    for (int d = 2; d <= 6; d++) expect_at(d, "R13", 11'h000, M_F);
    tick(1); batch_done = 1'b0;
    tick(7);

    // R11 external falling edge aborts
    ext_lvl = 1'b0;
    expect_at(1, "R11", 11'h000, M_F);
    expect_at(2, "R11", 11'h400, M_F);
    expect_at(3, "R11", 11'h000, M_F);
    tick(4); ext_lvl = 1'b1; tick(4);

    // R12 no abort without active transfer
    transfer_active = 1'b0; ext_lvl = 1'b0;
    expect_at(2, "R12", 11'h000, M_F);
    tick(4); ext_lvl = 1'b1; tick(4);

    // R12 no abort with pin function off
    gpio_oe = 1'b0;
    reg_write(8'h00, 4'h0, 8'h00, "R3");
    transfer_active = 1'b1; ext_lvl = 1'b0;
    expect_at(2, "R12", 11'h000, M_F);
    expect_at(3, "R12", 11'h000, M_F);
    tick(6);
    done = 1'b1;
  end

  initial begin
    for (int w = 0; w < 5000 && !done; w++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    if (q_cyc.size() != 0) begin
      failures++;
      checks++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", q_cyc.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule